// File: doc/BRIEF.md
# Masked Chip-Select Bank Decoder

This block sits between a processor's external-memory request path and four external memory banks. For every request it compares the 32-bit address against a programmable base and mask for each bank. It then reports one of three results one clock later: a one-hot chip select for the bank that claims the address, a miss, or a write-protect violation. Along with a chip select it reports the port width of the selected bank (8 or 16 bits).

Bank 0 needs no software setup. Reset leaves it valid and covering an 8-Mbyte window at the top of the address space, so the processor can fetch its first instructions before any register has been written. The port width of bank 0 comes from a strap input, which is sampled while reset is held. Software later reprograms any bank through a small address/data/strobe register port.

Top module: `cs_bank_decoder`

## Requirements
- R1: A valid bank hits a request when `(req_addr & mask) == (base & mask)` over all 32 address bits. A bank whose valid bit is clear never hits.
- R2: When a mask is written, its lowest 15 bits are stored as zero. Address bits 14:0 therefore never affect a hit, so the smallest bank is 32 Kbytes.
- R3: When several banks hit, only the lowest-numbered hitting bank is selected. `cs_sel` is never more than one-hot, and bit n of `cs_sel` selects bank n.
- R4: A request that no valid bank hits raises `miss` for one cycle and drives no chip select.
- R5: A write (`req_write`=1) whose selected bank has its protect bit set drives no chip select and raises `wp_err` for one cycle. A read of the same bank is selected normally.
- R6: After reset, bank 0 has base 0xFF80_0000, mask 0xFF80_0000, valid set and protect clear. Banks 1 to 3 are invalid.
- R7: Bank 0's port-width bit takes the value of `boot_port16` while `rst` is high. With every chip select, `cs_port16` reports the selected bank's port-width bit (1 = 16-bit, 0 = 8-bit). Without a chip select it is 0.
- R8: When `cfg_we` is high, the register port updates bank `cfg_bank` according to `cfg_field`:
  - 0: base from `cfg_wdata`.
  - 1: mask from `cfg_wdata`.
  - 2: control, where `cfg_wdata[0]` is valid, `cfg_wdata[1]` is port16 and `cfg_wdata[2]` is protect.
  - 3: ignored.

  The new values apply to requests from the next cycle onward.
- R9: Outputs are registered. The result of a request sampled at clock edge k appears after edge k. Without a request, `cs_sel`, `miss`, `wp_err` and `cs_port16` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_port16 | input | 1 | Strap for bank 0 port width, sampled during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_bank | input | 2 | Bank index for a register write |
| cfg_field | input | 2 | Field select: 0 base, 1 mask, 2 control, 3 none |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request address |
| cs_sel | output | 4 | One-hot chip select (registered) |
| cs_port16 | output | 1 | Port width of the selected bank |
| miss | output | 1 | No bank claimed the request |
| wp_err | output | 1 | Write rejected by a protected bank |

## Verification
The assertions assume the following about software and the request stream:
- Software writes only masks that are a contiguous run of ones from bit 31 downward.
- `req_write` has meaning only while `req_valid` is high.
- A register write and a request may share a cycle, and the request then sees the old settings.

The random stimulus builds every mask from a random bank size between 32 Kbytes and 64 Mbytes. It steers most addresses near a programmed base, so that hits, overlaps and misses all occur. Directed cases cover:
- the reset defaults;
- the ignored low mask bits;
- overlapping banks;
- protected writes;
- the unused field code;
- a second reset with the other strap value.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int ADDR_W        = 32;
  localparam int DONTCARE_BITS = 15;
  localparam logic [ADDR_W-1:0] BOOT_BASE = 32'hFF80_0000;
  localparam logic [ADDR_W-1:0] BOOT_MASK = 32'hFF80_0000;
  localparam logic [ADDR_W-1:0] MASK_KEEP =
    {{(ADDR_W-DONTCARE_BITS){1'b1}}, {DONTCARE_BITS{1'b0}}};

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } cfg_field_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic              valid;
    logic              port16;
    logic              wprot;
  } bank_cfg_t;
endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            boot_port16,
  input  logic                            cfg_we,
  input  logic [BANK_IDX_W-1:0]           cfg_bank,
  input  logic [1:0]                      cfg_field,
  input  logic [ADDR_W-1:0]               cfg_wdata,
  output bank_cfg_t [NUM_BANKS-1:0]       cfg_q
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = cfg_we && (cfg_bank == BANK_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        if (g == 0) begin
          cfg_q[g].base   <= BOOT_BASE;
          cfg_q[g].mask   <= BOOT_MASK;
          cfg_q[g].valid  <= 1'b1;
          cfg_q[g].port16 <= boot_port16;
          cfg_q[g].wprot  <= 1'b0;
        end else begin
          cfg_q[g] <= '0;
        end
      end else if (sel) begin
        case (cfg_field_e'(cfg_field))
          FLD_BASE: cfg_q[g].base <= cfg_wdata;
          FLD_MASK: cfg_q[g].mask <= cfg_wdata & MASK_KEEP;
          FLD_CTRL: begin
            cfg_q[g].valid  <= cfg_wdata[0];
            cfg_q[g].port16 <= cfg_wdata[1];
            cfg_q[g].wprot  <= cfg_wdata[2];
          end
          default: ;
        endcase
      end
    end

    AST_LOW_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
      cfg_q[g].mask[DONTCARE_BITS-1:0] == '0) else $error("low mask bits set"); // R2
  end

  AST_BOOT_DEFAULT: assert property (@(posedge clk)
    $fell(rst) |-> (cfg_q[0].valid && cfg_q[0].base == BOOT_BASE &&
                    cfg_q[0].mask == BOOT_MASK && !cfg_q[0].wprot))
    else $error("boot bank not ready"); // R6

endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [ADDR_W-1:0]         addr,
  input  bank_cfg_t [NUM_BANKS-1:0] cfg,
  output logic [NUM_BANKS-1:0]      hit
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    assign hit[g] = cfg[g].valid && (((addr ^ cfg[g].base) & cfg[g].mask) == '0);
  end
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     hit,
  output logic [N-1:0]     win_oh,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_oh  = '0;
        win_oh[i] = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
  assign any = |hit;
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  boot_port16,
  input  logic                  cfg_we,
  input  logic [BANK_IDX_W-1:0] cfg_bank,
  input  logic [1:0]            cfg_field,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic [NUM_BANKS-1:0]  cs_sel,
  output logic                  cs_port16,
  output logic                  miss,
  output logic                  wp_err
);

  bank_cfg_t [NUM_BANKS-1:0] cfg_q;
  logic [NUM_BANKS-1:0]      hit, win_oh;
  logic [BANK_IDX_W-1:0]     win_idx;
  logic                      any_hit, blocked;

  cs_bank_regs #(.NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)) regs_i (
    .clk(clk), .rst(rst), .boot_port16(boot_port16), .cfg_we(cfg_we),
    .cfg_bank(cfg_bank), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q)
  );

  cs_bank_match #(.NUM_BANKS(NUM_BANKS)) match_i (
    .addr(req_addr), .cfg(cfg_q), .hit(hit)
  );

  cs_prio_sel #(.N(NUM_BANKS), .IDX_W(BANK_IDX_W)) prio_i (
    .hit(hit), .win_oh(win_oh), .win_idx(win_idx), .any(any_hit)
  );

  assign blocked = req_write && cfg_q[win_idx].wprot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sel    <= '0;
      cs_port16 <= 1'b0;
      miss      <= 1'b0;
      wp_err    <= 1'b0;
    end else begin
      cs_sel    <= (req_valid && any_hit && !blocked) ? win_oh : '0;
      cs_port16 <= req_valid && any_hit && !blocked && cfg_q[win_idx].port16;
      miss      <= req_valid && !any_hit;
      wp_err    <= req_valid && any_hit && blocked;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel)) else $error("multiple chip selects"); // R3
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    miss |-> (cs_sel == '0 && !wp_err)) else $error("miss with select"); // R4
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    wp_err |-> (cs_sel == '0 && !cs_port16)) else $error("protected write selected"); // R5
  AST_WP_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    wp_err |-> $past(req_write)) else $error("wp_err on read"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (cs_sel == '0 && !miss && !wp_err && !cs_port16))
    else $error("output without request"); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(rst)) |-> $countones({|cs_sel, miss, wp_err}) == 1)
    else $error("request without single result"); // R9

endmodule

// File: tb/cs_bank_decoder_tb_top.sv
module cs_bank_decoder_tb_top;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_port16 = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [1:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  cs_sel;
  logic        cs_port16, miss, wp_err;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_base [NB];
  logic [31:0] m_mask [NB];
  logic        m_val [NB];
  logic        m_p16 [NB];
  logic        m_wp  [NB];

  always #10 clk = ~clk;

  cs_bank_decoder dut_i (
    .clk(clk), .rst(rst), .boot_port16(boot_port16), .cfg_we(cfg_we),
    .cfg_bank(cfg_bank), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .cs_sel(cs_sel), .cs_port16(cs_port16), .miss(miss), .wp_err(wp_err)
  );

  // response packed as {cs[3:0], port16, miss, wp_err}
  function automatic logic [6:0] expect_resp(input logic [31:0] a, input logic wr);
    for (int b = 0; b < NB; b++) begin
      if (m_val[b] && ((a & m_mask[b]) == (m_base[b] & m_mask[b]))) begin
        if (wr && m_wp[b]) return 7'b0000_001;
        return {4'(1 << b), m_p16[b], 2'b00};
      end
    end
    return 7'b0000_010;
  endfunction

  function automatic logic [31:0] size_mask(input int k);
    return ~((32'd1 << k) - 32'd1);
  endfunction

  task automatic model_reset(input logic strap);
    for (int b = 0; b < NB; b++) begin
      m_base[b] = '0; m_mask[b] = '0; m_val[b] = 0; m_p16[b] = 0; m_wp[b] = 0;
    end
    m_base[0] = 32'hFF80_0000; m_mask[0] = 32'hFF80_0000; m_val[0] = 1; m_p16[0] = strap;
  endtask

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; boot_port16 = strap; req_valid = 0; cfg_we = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset(strap);
  endtask

  task automatic cfg_write(input int b, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      2'd0: m_base[b] = d;
      2'd1: m_mask[b] = d & 32'hFFFF_8000;
      2'd2: begin m_val[b] = d[0]; m_p16[b] = d[1]; m_wp[b] = d[2]; end
      default: ;
    endcase
  endtask

  task automatic request(input string tag, input logic [31:0] a, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(posedge clk);
    #1;
    chk(tag, {cs_sel, cs_port16, miss, wp_err}, expect_resp(a, wr));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    @(posedge clk); #1;
    chk("R9 idle after reset", {cs_sel, cs_port16, miss, wp_err}, 7'b0);
    request("R6 R7 boot bank hit, 16-bit strap", 32'hFF80_1234, 1'b0);
    request("R6 boot bank top edge", 32'hFFFF_FFFC, 1'b1);
    request("R4 R6 miss below boot bank", 32'hFF7F_FFFF, 1'b0);
    request("R4 R6 banks 1-3 invalid", 32'h0000_0000, 1'b0);

    cfg_write(1, 2'd0, 32'h1000_0000);
    cfg_write(1, 2'd1, 32'hFFFF_FFFF);
    cfg_write(1, 2'd2, 32'h0000_0001);
    request("R2 low bits ignored", 32'h1000_7FFF, 1'b0);
    request("R1 bit 15 compared", 32'h1000_8000, 1'b0);

    cfg_write(2, 2'd0, 32'h1000_0000);
    cfg_write(2, 2'd1, size_mask(24));
    cfg_write(2, 2'd2, 32'h0000_0003);
    request("R3 overlap lower bank wins", 32'h1000_0010, 1'b0);
    request("R3 R7 only bank 2 hits, 16-bit", 32'h10F0_0000, 1'b0);

    cfg_write(1, 2'd2, 32'h0000_0005);
    request("R5 protected write blocked", 32'h1000_0040, 1'b1);
    request("R5 protected read passes", 32'h1000_0040, 1'b0);
    cfg_write(1, 2'd3, 32'h0000_0000);
    request("R8 field 3 ignored", 32'h1000_0040, 1'b0);
    cfg_write(2, 2'd2, 32'h0000_0000);
    request("R1 R8 invalidated bank never hits", 32'h10F0_0000, 1'b0);

    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel == 0) begin
        int b = int'($urandom_range(0, NB - 1));
        int f = int'($urandom_range(0, 3));
        logic [31:0] d;
        if (f == 1) d = size_mask(int'($urandom_range(15, 26)));
        else if (f == 2) d = 32'($urandom_range(0, 7));
        else d = $urandom;
        cfg_write(b, 2'(f), d);
      end else begin
        int b = int'($urandom_range(0, NB - 1));
        logic [31:0] a;
        if (sel < 8) a = m_base[b] ^ (32'($urandom) & ((32'd1 << $urandom_range(8, 27)) - 32'd1));
        else a = $urandom;
        request("R1 R3 R4 R5 random", a, 1'($urandom_range(0, 1)));
      end
    end

    do_reset(1'b0);
    request("R6 R7 reset re-arms boot bank, 8-bit", 32'hFFC0_0000, 1'b0);
    request("R6 bank 1 cleared by reset", 32'h1000_0040, 1'b0);
    @(posedge clk); #1;
    chk("R9 no request no output", {cs_sel, cs_port16, miss, wp_err}, 7'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule